// File: doc/BRIEF.md
# Glitch-Free Output Clock Disable Controller

This block drives a bank of divided clock outputs from a single fast system clock. Each output has its own divider, an enable request, a level to hold while it is stopped, and a mode bit. The mode bit selects how a stop request is handled. In deferred mode the output finishes its current period before it stops, so no shortened high or low pulse can appear. In immediate mode the output stops on the next edge.

A restart always waits for the next period boundary, so the first pulse after a restart has full width. The per-output settings are held in a small register file that is loaded through a byte-wide write port, with one address for each output. A status bit for each output shows whether that output is currently held at its parked level.

Top module: `clk_park_bank`

## Requirements
- R1: While reset is asserted and after its release, every clock output is low, every parked bit is 1, and every control byte reads as zero (immediate mode, park low).
- R2: Each output has a phase counter. The counter is 0 when reset is released, advances on every rising edge, including while the output is parked, and wraps after N-1, where N (at least 2) is the output's divisor. After the edge that brings the counter to phase p, a running output is high when p < floor(N/2) and low otherwise.
- R3: In immediate mode (control bit 3 = 0), a running output whose request is seen low at an edge is parked from that edge on.
- R4: In deferred mode (control bit 3 = 1), a running output with its request low parks only at the first edge that brings its phase to 0. It runs normally until then.
- R5: The parked level comes from control bits [5:4]: 2'b01 parks high, 2'b00 parks low, and 2'b10 and 2'b11 park low. A written value applies from the write edge itself.
- R6: Deferred mode is off after reset, so an output whose control byte was never written stops immediately.
- R7: A parked output whose request is high starts running at the first edge that brings its phase to 0. Its first high pulse lasts floor(N/2) cycles.
- R8: If the request comes back high before any edge that would end a pending deferred stop, the output keeps running without a break.
- R9: A write to address k (below the output count) changes only output k's control byte. Writes to higher addresses change nothing. The outputs operate independently of one another.
- R10: The parked status bit is 1 exactly on the cycles when the output is held at its parked level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_addr | input | ADDR_W | Output index for the write |
| wr_data | input | 8 | Control byte: [5:4] parked level, [3] deferred mode |
| en_req | input | NUM_OUT | Per-output run request |
| div_n | input | NUM_OUT*DIV_W | Per-output divisor, output k in bits [k*DIV_W +: DIV_W] |
| clk_out | output | NUM_OUT | Divided clock outputs |
| parked | output | NUM_OUT | 1 while the output is held at its parked level |

## Verification
The assertions assume that every divisor is at least 2 and stays constant during a run. If a divisor changed, the phase arithmetic used by the start-alignment and deferred-stop checks would no longer hold. The bench ties each divisor to a fixed value between 2 and 11 and changes only the requests and the control bytes. It changes requests at chosen phases, mid-pulse for an immediate stop and away from phase 0 when a deferred stop is withdrawn, so that both the deferred and the aborted stop paths are exercised.

// File: rtl/clk_park_bank.sv
`timescale 1ns/1ps
module clk_park_bank #(
  parameter int NUM_OUT = 10,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = $clog2(NUM_OUT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [NUM_OUT-1:0]       en_req,
  input  logic [NUM_OUT*DIV_W-1:0] div_n,
  output logic [NUM_OUT-1:0]       clk_out,
  output logic [NUM_OUT-1:0]       parked
);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [2:0]       cfg_q, cfg_d;
    logic [DIV_W-1:0] cnt_q, cnt_d, n, half;
    logic             run_q, run_d, out_q, sync_d, lvl_d, wrap;

    assign n      = div_n[g*DIV_W +: DIV_W];
    assign half   = n >> 1;
    assign cfg_d  = (wr_en && wr_addr == ADDR_W'(g)) ? wr_data[5:3] : cfg_q;
    assign sync_d = cfg_d[0];
    assign lvl_d  = (cfg_d[2:1] == 2'b01);
    assign wrap   = (cnt_q >= n - DIV_W'(1));
    assign cnt_d  = wrap ? '0 : cnt_q + DIV_W'(1);

    always_comb begin
      if (run_q) run_d = en_req[g] || (sync_d && cnt_d != '0);
      else       run_d = en_req[g] && cnt_d == '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q <= '0;
        cnt_q <= '0;
        run_q <= 1'b0;
        out_q <= 1'b0;
      end else begin
        cfg_q <= cfg_d;
        cnt_q <= cnt_d;
        run_q <= run_d;
        out_q <= run_d ? (cnt_d < half) : lvl_d;
      end
    end

    assign clk_out[g] = out_q;
    assign parked[g]  = ~run_q;

    AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      n >= DIV_W'(2)); // R2
    AST_HIGH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q == '0) |-> clk_out[g]); // R2
    AST_IMM_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !en_req[g] && !sync_d) |=> parked[g]); // R3
    AST_SYNC_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_q) && $past(sync_d)) |-> cnt_q == '0); // R4
    AST_PARK_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> clk_out[g] == (cfg_q[2:1] == 2'b01)); // R5
    AST_REN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> cnt_q == '0); // R7
    AST_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en_req[g]) |=> !parked[g]); // R8
  end

endmodule

// File: tb/clk_park_bank_test.sv
`timescale 1ns/1ps
module clk_park_bank_test;
  localparam int NUM_OUT = 10;
  localparam int DIV_W   = 8;
  localparam int ADDR_W  = $clog2(NUM_OUT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NUM_OUT-1:0] en_req = '0;
  logic [NUM_OUT*DIV_W-1:0] div_n;
  logic [NUM_OUT-1:0] clk_out, parked;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_div
    assign div_n[i*DIV_W +: DIV_W] = DIV_W'(i + 2);
  end

  clk_park_bank #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_req(en_req), .div_n(div_n), .clk_out(clk_out), .parked(parked));

  always #4 clk = ~clk;

  typedef struct {
    int    at;
    int    idx;
    bit    out;
    bit    pk;
    string req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int t = 0;

  always @(posedge clk) if (rst_n) t <= t + 1;

  function automatic int divof(int i);
    return i + 2;
  endfunction

  function automatic int first_zero(int e, int n);
    return e + ((n - (e % n)) % n);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at t=%0d: actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  task automatic push_park(int idx, int from, int len, bit lvl, string req);
    for (int k = 0; k < len; k++) sb.push_back('{from + k, idx, lvl, 1'b1, req});
  endtask

  task automatic push_run(int idx, int from, int len, string req);
    int n = divof(idx);
    for (int k = 0; k < len; k++)
      sb.push_back('{from + k, idx, ((from + k) % n) < (n / 2), 1'b0, req});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = sb.size() - 1; k >= 0; k--) begin
        if (sb[k].at == t) begin
          chk(clk_out[sb[k].idx] == sb[k].out, {sb[k].req, " out"},
              int'(clk_out[sb[k].idx]), int'(sb[k].out));
          chk(parked[sb[k].idx] == sb[k].pk, {sb[k].req, " parked (R10)"},
              int'(parked[sb[k].idx]), int'(sb[k].pk));
          sb.delete(k);
        end else if (sb[k].at < t) begin
          chk(1'b0, {sb[k].req, " missed"}, sb[k].at, t);
          sb.delete(k);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic write_cfg(int addr, logic [7:0] data);
    wr_addr = ADDR_W'(addr);
    wr_data = data;
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_phase(int idx, int ph);
    do step(); while ((t % divof(idx)) != ph);
  endtask

  task automatic drain();
    while (sb.size() != 0) step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int e;
    int s;
    repeat (3) @(negedge clk);
    chk(clk_out == '0, "R1 reset outputs", int'(clk_out), 0);
    chk(parked == '1, "R1 reset parked", int'(parked), (1 << NUM_OUT) - 1);
    step();
    rst_n = 1'b1;
    step();
    push_park(0, t + 1, 3, 1'b0, "R1 after reset");
    push_park(9, t + 1, 3, 1'b0, "R1 after reset");
    drain();

    e = t + 1;
    write_cfg(3, 8'h10);
    push_park(3, e, 4, 1'b1, "R5 level 01");
    e = t + 1;
    write_cfg(4, 8'h20);
    push_park(4, e, 4, 1'b0, "R5 level 10");
    e = t + 1;
    write_cfg(12, 8'h18);
    for (int i = 0; i < NUM_OUT; i++) push_park(i, e, 4, i == 3, "R9 high address");
    drain();

    e = t + 1;
    en_req = '1;
    for (int i = 0; i < NUM_OUT; i++) begin
      s = first_zero(e, divof(i));
      push_park(i, e, s - e, i == 3, "R7 wait for start");
      push_run(i, s, 2 * divof(i), "R2/R7 run");
    end
    drain();

    wait_phase(5, 0);
    e = t + 1;
    en_req[5] = 1'b0;
    push_park(5, e, 10, 1'b0, "R3/R6 immediate stop");
    push_run(6, e, 10, "R9 neighbour runs");
    drain();

    write_cfg(6, 8'h18);
    wait_phase(6, 1);
    e = t + 1;
    en_req[6] = 1'b0;
    s = first_zero(e, 8);
    push_run(6, e, s - e, "R4 finish period");
    push_park(6, s, 6, 1'b1, "R4 deferred park");
    drain();

    write_cfg(7, 8'h08);
    wait_phase(7, 2);
    e = t + 1;
    en_req[7] = 1'b0;
    push_run(7, e, 27, "R8 withdrawn stop");
    step();
    step();
    en_req[7] = 1'b1;
    drain();

    wait_phase(6, 2);
    e = t + 1;
    en_req[6] = 1'b1;
    s = first_zero(e, 8);
    push_park(6, e, s - e, 1'b1, "R7 restart wait");
    push_run(6, s, 16, "R7 full first pulse");
    wait_phase(5, 4);
    e = t + 1;
    en_req[5] = 1'b1;
    s = first_zero(e, 7);
    push_park(5, e, s - e, 1'b0, "R7 restart wait");
    push_run(5, s, 14, "R7 full first pulse");
    drain();

    summary();
  end
endmodule